// File: doc/BRIEF.md
# Write Completion Status Responder

This block sits in the read path of a byte-wide nonvolatile memory controller. While an internal page-write or chip-erase cycle is running, the array cannot be read, so host reads get a status byte in place of array data. The host polls that byte to learn when the cycle has ended. Two encodings share the byte. The polling bit is the inverse of the matching bit of the last byte loaded into the page, and it is given only for page writes. The toggle bit flips on every read during any kind of cycle. Once the busy flag drops, reads return the array data again.

The block detects the start of a cycle at the rising edge of `busy_i`. At that edge it captures the cycle kind and the last loaded byte, and it clears its toggle state. Each read strobe gets a registered response one clock later. The choice between status and array data is made for the whole byte, using `busy_i` as sampled at the read's own clock edge.

Top module: `wcs_responder`

## Requirements
- R1: While `rst_ni` is low and straight after reset, `rd_valid_o` is 0 and `rd_data_o` is 0.
- R2: A read strobe `rd_i` sampled at a clock edge makes `rd_valid_o` high for exactly the following cycle, with the response on `rd_data_o`. A cycle without a strobe leaves `rd_valid_o` low in the following cycle.
- R3: A read sampled while `busy_i` is low returns `array_data_i` unchanged.
- R4: During a page-write cycle (`erase_i` = 0 at start), a read returns bit 7 as the complement of bit 7 of the last loaded byte, and bits 5..0 as 0.
- R5: During any cycle, bit 6 of successive reads alternates. The first read after a cycle starts returns 1, including a read in the very cycle that `busy_i` rises.
- R6: During a chip-erase cycle (`erase_i` = 1 at start), a read returns bit 7 as 0 (no polling), bit 6 as the toggle bit, and bits 5..0 as 0.
- R7: The cycle kind and last loaded byte are captured at the rising edge of `busy_i`. Changes to `erase_i` or `last_byte_i` while the cycle runs have no effect on the returned status.
- R8: After `busy_i` falls, toggling stops. Two back-to-back reads of an unchanged array return the same bit 6.
- R9: A read sampled in the first cycle with `busy_i` low returns the full array byte, with no status bit mixed in.
- R10: Clock cycles without a read strobe do not advance the toggle bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| busy_i | input | 1 | Internal write or erase cycle in progress |
| erase_i | input | 1 | Cycle kind at start: 0 page write, 1 chip erase |
| last_byte_i | input | DATA_W | Last byte loaded into the page buffer |
| rd_i | input | 1 | Read strobe |
| array_data_i | input | DATA_W | Normal array read data |
| rd_data_o | output | DATA_W | Registered read response |
| rd_valid_o | output | 1 | Response valid, one cycle after `rd_i` |

## Verification
The bench reads in the same cycle that `busy_i` rises. A design that clears its toggle state one cycle late would return 0 there instead of 1. It changes `erase_i` and `last_byte_i` partway through a cycle. A design that reads these inputs live would flip the polling bit or drop polling. It reads in the exact cycle that `busy_i` falls and then twice more afterwards. A design that registers the mode selection would leak a status byte, and one that keeps toggling after completion would fail the repeated reads. Idle cycles placed between reads expose a toggle that counts clocks instead of reads.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  typedef enum logic {
    CYC_PAGE  = 1'b0,
    CYC_ERASE = 1'b1
  } cyc_kind_e;
endpackage

// File: rtl/wcs_cycle_tracker.sv
module wcs_cycle_tracker
  import wcs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              erase_i,
  input  logic [DATA_W-1:0] last_byte_i,
  output logic              start_o,
  output cyc_kind_e         kind_o,
  output logic [DATA_W-1:0] last_o
);
  logic              busy_q;
  cyc_kind_e         kind_q;
  logic [DATA_W-1:0] last_q;

  assign start_o = busy_i && !busy_q;
  // capture applies to a read in the start cycle itself
  assign kind_o  = start_o ? cyc_kind_e'(erase_i) : kind_q;
  assign last_o  = start_o ? last_byte_i : last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      kind_q <= CYC_PAGE;
      last_q <= '0;
    end else begin
      busy_q <= busy_i;
      if (start_o) begin
        kind_q <= cyc_kind_e'(erase_i);
        last_q <= last_byte_i;
      end
    end
  end

  // R7
  captured_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !start_o) |=> (busy_i && !start_o) -> ($stable(kind_q) && $stable(last_q)));
endmodule

// File: rtl/wcs_toggle.sv
module wcs_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic busy_i,
  input  logic rd_i,
  output logic tog_o
);
  logic tog_q, base, tog_d;

  assign base  = start_i ? 1'b0 : tog_q;
  assign tog_d = (rd_i && busy_i) ? ~base : base;
  assign tog_o = tog_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= 1'b0;
    else         tog_q <= tog_d;
  end

  // R10
  idle_no_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !start_i) |=> $stable(tog_q));
  // R5
  first_read_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && rd_i) |=> tog_q);
endmodule

// File: rtl/wcs_encoder.sv
module wcs_encoder
  import wcs_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  logic              busy_i,
  input  cyc_kind_e         kind_i,
  input  logic [DATA_W-1:0] last_i,
  input  logic              tog_i,
  input  logic [DATA_W-1:0] array_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] status;

  always_comb begin
    status             = '0;
    status[TOGGLE_BIT] = tog_i;
    if (kind_i == CYC_PAGE) status[POLL_BIT] = ~last_i[POLL_BIT];
  end

  // single select for the whole byte
  assign data_o = busy_i ? status : array_i;
endmodule

// File: rtl/wcs_responder.sv
module wcs_responder
  import wcs_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              erase_i,
  input  logic [DATA_W-1:0] last_byte_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  localparam int STATUS_BITS = 2;
  initial begin
    if (POLL_BIT == TOGGLE_BIT || POLL_BIT >= DATA_W || TOGGLE_BIT >= DATA_W
        || DATA_W < STATUS_BITS)
      $error("wcs_responder: bad bit positions");
  end

  logic              start;
  cyc_kind_e         kind;
  logic [DATA_W-1:0] last_sel;
  logic              tog;
  logic [DATA_W-1:0] enc_data;

  wcs_cycle_tracker #(.DATA_W(DATA_W)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_i      (busy_i),
    .erase_i     (erase_i),
    .last_byte_i (last_byte_i),
    .start_o     (start),
    .kind_o      (kind),
    .last_o      (last_sel)
  );

  wcs_toggle u_tog (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .busy_i  (busy_i),
    .rd_i    (rd_i),
    .tog_o   (tog)
  );

  wcs_encoder #(.DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TOGGLE_BIT(TOGGLE_BIT)) u_enc (
    .busy_i  (busy_i),
    .kind_i  (kind),
    .last_i  (last_sel),
    .tog_i   (tog),
    .array_i (array_data_i),
    .data_o  (enc_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_i;
      if (rd_i) rd_data_o <= enc_data;
    end
  end

  // R2
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rd_valid_o);
  // R2
  no_spurious_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rd_valid_o);
  // R3
  idle_passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !busy_i) |=> rd_data_o == $past(array_data_i));
  // R4
  poll_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && busy_i && kind == CYC_PAGE) |=> rd_data_o[POLL_BIT] == ~$past(last_sel[POLL_BIT]));
  // R6
  erase_no_poll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && busy_i && kind == CYC_ERASE) |=> !rd_data_o[POLL_BIT]);
endmodule

// File: tb/wcs_responder_test.sv
module wcs_responder_test;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       busy_i = 1'b0;
  logic       erase_i = 1'b0;
  logic [7:0] last_byte_i = '0;
  logic       rd_i = 1'b0;
  logic [7:0] array_data_i = '0;
  logic [7:0] rd_data_o;
  logic       rd_valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit mon_en = 0;

  typedef struct {
    logic       valid;
    logic [7:0] data;
    string      tag;
  } item_t;
  item_t exp_q[$];

  // reference model state
  logic       m_busy = 0;
  logic       m_kind = 0;
  logic [7:0] m_last = 0;
  logic       m_tog = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wcs_responder uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy_i), .erase_i(erase_i),
    .last_byte_i(last_byte_i), .rd_i(rd_i), .array_data_i(array_data_i),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
  );

  task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // driver: called at a negedge, drives one cycle and pushes the expectation
  task automatic step(logic rd, logic busy, logic erase, logic [7:0] last,
                      logic [7:0] arr, string tag);
    item_t it;
    rd_i = rd; busy_i = busy; erase_i = erase; last_byte_i = last; array_data_i = arr;
    if (busy && !m_busy) begin
      m_kind = erase; m_last = last; m_tog = 0;
    end
    if (rd && busy) m_tog = ~m_tog;
    it.valid = rd;
    it.tag   = tag;
    it.data  = busy ? {(m_kind ? 1'b0 : ~m_last[7]), m_tog, 6'b0} : arr;
    m_busy = busy;
    exp_q.push_back(it);
    @(negedge clk_i);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #(CLK_PERIOD/4);
      if (mon_en && exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        check({it.tag, " R2 valid"}, {8'h0, rd_valid_o}, {8'h0, it.valid});
        if (it.valid) check(it.tag, {1'b0, rd_data_o}, {1'b0, it.data});
      end
    end
  end

  initial begin
    #(CLK_PERIOD*20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset valid", {8'h0, rd_valid_o}, 9'h0);
    check("R1 reset data", {1'b0, rd_data_o}, 9'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 post-reset", {rd_data_o, rd_valid_o}, 9'h0);
    mon_en = 1;

    // R3 idle reads
    step(1, 0, 0, 8'h00, 8'h3C, "R3 idle a");
    step(1, 0, 0, 8'h00, 8'hA5, "R3 idle b");
    step(0, 0, 0, 8'h00, 8'hA5, "R2 no read");

    // page write, last byte bit7 = 0
    step(0, 1, 0, 8'h5A, 8'h11, "R5 start no read");
    step(1, 1, 0, 8'h5A, 8'h11, "R4 R5 first read");
    step(0, 1, 0, 8'h5A, 8'h11, "R10 idle");
    step(0, 1, 0, 8'h5A, 8'h11, "R10 idle");
    step(1, 1, 0, 8'h5A, 8'h11, "R5 second read");
    step(1, 1, 1, 8'hFF, 8'h11, "R7 inputs changed");
    step(1, 1, 1, 8'hFF, 8'h11, "R7 inputs changed 2");
    // falling edge: read in first idle cycle
    step(1, 0, 0, 8'hFF, 8'h6B, "R9 fall read");
    step(1, 0, 0, 8'hFF, 8'h6B, "R8 repeat a");
    step(1, 0, 0, 8'hFF, 8'h6B, "R8 repeat b");

    // page write, last bit7 = 1, read on start cycle
    step(1, 1, 0, 8'hC3, 8'h00, "R5 read at start");
    step(1, 1, 0, 8'h00, 8'h00, "R4 polling low");
    step(0, 0, 0, 8'h00, 8'hFF, "R2 gap");
    step(1, 0, 0, 8'h00, 8'hFF, "R9 all ones");

    // erase cycle
    step(0, 1, 1, 8'h00, 8'h00, "R6 start");
    step(1, 1, 1, 8'h00, 8'h00, "R6 read a");
    step(1, 1, 0, 8'h7F, 8'h00, "R6 R7 read b");
    step(1, 1, 0, 8'h7F, 8'h00, "R6 read c");
    step(1, 0, 0, 8'h7F, 8'hC0, "R9 after erase");
    step(1, 0, 0, 8'h7F, 8'hC0, "R8 steady");
    step(0, 0, 0, 8'h7F, 8'hC0, "R2 tail");

    @(negedge clk_i);
    @(negedge clk_i);
    summary();
  end
endmodule